// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the device side of a byte-wide flash bus with a 16-bit address. Each write cycle arrives already latched as one address and one data byte. The block walks a short state machine through the two-write unlock key. After the key it decides which operation the host asked for: byte program, whole-array erase, erase of one 4 KB page, one-time lockout of the top or bottom 8 KB boot region, or entry to or exit from identification mode. When an operation is recognised, the block issues a single-cycle start pulse to the array controller together with the target address and data.

Boot-region lock bits live inside the block. They veto program and erase starts that would touch a locked region. While identification mode is active, a read-data port returns the maker code, the device code and the lock status in place of array data. When the array controller raises its busy line, incoming writes have no effect. Any write that does not continue a valid sequence drops the machine back to plain read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the machine is in read mode. Identification mode is off, both lock bits are 0, no start pulse is active and `id_data_o` reads 0x00.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, followed by any fourth write, produce one `prog_start_o` pulse. The pulse appears in the cycle after the fourth write is sampled, with that write's address and data on `op_addr_o`/`op_data_o`.
- R3: The six-write sequence (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555) produces one `chip_erase_o` pulse.
- R4: The same five-write prefix followed by 0x50 at any address produces one `page_erase_o` pulse. `op_addr_o` carries that address, and its upper 4 bits name the 4 KB page.
- R5: The five-write prefix, then 0x70@0x5555, then a write to 0xFFFF sets `lock_top_o`; a write to 0x0000 in that last slot sets `lock_bot_o` instead. A write to any other address in that slot sets neither bit. Once set, a lock bit stays set until reset.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555 set `id_mode_o`. It clears after 0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555, or after a single write of 0xF0 to any address.
- R7: In identification mode, `id_data_o` is combinational from `rd_addr_i`. Read addresses 0x0002 and 0xFFF2 return the bottom and top lock bit in bit 0, with all other bits 0. Otherwise, read-address low byte 0x00 returns the maker code (default 0xC5) and low byte 0x01 returns the device code (default 0x1B). Every other case returns 0x00.
- R8: A write whose address (all 16 bits) or data does not continue a valid sequence returns the machine to read mode and clears identification mode, without any start pulse.
- R9: A write presented while `busy_i` is high is ignored. Sequence position and identification mode are unchanged.
- R10: A program or page erase whose address falls in a locked region is suppressed; the top region is 0xE000–0xFFFF and the bottom region is 0x0000–0x1FFF. A chip erase is suppressed while either lock bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One latched bus write is presented this cycle |
| wr_addr_i | input | 16 | Address of the write |
| wr_data_i | input | 8 | Data of the write |
| busy_i | input | 1 | Embedded operation in progress; writes ignored |
| rd_addr_i | input | 16 | Read address for identification data |
| prog_start_o | output | 1 | Single-cycle byte program start |
| chip_erase_o | output | 1 | Single-cycle whole-array erase start |
| page_erase_o | output | 1 | Single-cycle page erase start |
| op_addr_o | output | 16 | Target address of the last started operation |
| op_data_o | output | 8 | Data of the last started operation |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 8 | Identification read data |
| lock_top_o | output | 1 | Top 8 KB region locked |
| lock_bot_o | output | 1 | Bottom 8 KB region locked |

## Verification
The clock edge that samples a write is the only point where sequence state, start pulses, address/data capture, lock bits and the identification flag change. All of these are therefore visible exactly one cycle after that edge. `id_data_o` is the one exception: it follows `rd_addr_i` in the same cycle. The bench drives every write on a falling edge and reads the registered results on the next falling edge, half a cycle after the capturing edge. For identification reads, it changes `rd_addr_i` on a falling edge and samples on the following falling edge, so no check depends on process order at the active edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_READ, SQ_KEY1, SQ_KEY2, SQ_PROG, SQ_ERS1, SQ_ERS2, SQ_ERS3, SQ_LOCK
  } seq_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PROG, CMD_CHIP, CMD_PAGE, CMD_LOCK_TOP, CMD_LOCK_BOT
  } cmd_e;

  localparam logic [7:0] C_KEY1    = 8'hAA;
  localparam logic [7:0] C_KEY2    = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_PAGE    = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h70;
  localparam logic [7:0] C_ID_ON   = 8'h90;
  localparam logic [7:0] C_ID_OFF  = 8'hF0;

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h2AAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              id_mode_o
);

  seq_e state_q, state_d;
  logic id_q, id_d;
  logic acc;
  logic at_a, at_b;

  assign acc  = wr_valid_i && !busy_i;
  assign at_a = (wr_addr_i == KEY_ADDR_A);
  assign at_b = (wr_addr_i == KEY_ADDR_B);

  function automatic logic is_code(input logic [DATA_W-1:0] d, input logic [7:0] c);
    return d == DATA_W'(c);
  endfunction

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    cmd_o   = CMD_NONE;
    if (acc) begin
      // default: abort to read mode
      state_d = SQ_READ;
      id_d    = 1'b0;
      unique case (state_q)
        SQ_READ: if (at_a && is_code(wr_data_i, C_KEY1)) begin
          state_d = SQ_KEY1; id_d = id_q;
        end
        SQ_KEY1: if (at_b && is_code(wr_data_i, C_KEY2)) begin
          state_d = SQ_KEY2; id_d = id_q;
        end
        SQ_KEY2: if (at_a) begin
          if (is_code(wr_data_i, C_PROG)) begin
            state_d = SQ_PROG; id_d = id_q;
          end else if (is_code(wr_data_i, C_ERASE)) begin
            state_d = SQ_ERS1; id_d = id_q;
          end else if (is_code(wr_data_i, C_ID_ON)) begin
            id_d = 1'b1;
          end
        end
        SQ_PROG: cmd_o = CMD_PROG;
        SQ_ERS1: if (at_a && is_code(wr_data_i, C_KEY1)) begin
          state_d = SQ_ERS2; id_d = id_q;
        end
        SQ_ERS2: if (at_b && is_code(wr_data_i, C_KEY2)) begin
          state_d = SQ_ERS3; id_d = id_q;
        end
        SQ_ERS3: begin
          if (at_a && is_code(wr_data_i, C_CHIP))      cmd_o = CMD_CHIP;
          else if (is_code(wr_data_i, C_PAGE))         cmd_o = CMD_PAGE;
          else if (at_a && is_code(wr_data_i, C_LOCK)) begin
            state_d = SQ_LOCK; id_d = id_q;
          end
        end
        SQ_LOCK: begin
          if (&wr_addr_i)       cmd_o = CMD_LOCK_TOP;
          else if (~|wr_addr_i) cmd_o = CMD_LOCK_BOT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_READ;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end

  assign cmd_addr_o = wr_addr_i;
  assign cmd_data_o = wr_data_i;
  assign id_mode_o  = id_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_q) && $stable(id_q));

  // R8
  cmd_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NONE) |=> (state_q == SQ_READ));

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BOOT_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              prog_start_o,
  output logic              chip_erase_o,
  output logic              page_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              lock_top_o,
  output logic              lock_bot_o
);

  localparam int REG_W = ADDR_W - BOOT_W;

  // index 0: bottom region, index 1: top region
  logic [1:0] lock_q, lock_set, in_reg;
  logic       blocked, any_lock;
  logic       prog_d, chip_d, page_d;

  for (genvar g = 0; g < 2; g++) begin : g_region
    if (g == 1) begin : g_top
      assign in_reg[g]   = &cmd_addr_i[ADDR_W-1:BOOT_W];
      assign lock_set[g] = (cmd_i == CMD_LOCK_TOP);
    end else begin : g_bot
      assign in_reg[g]   = ~|cmd_addr_i[ADDR_W-1:BOOT_W];
      assign lock_set[g] = (cmd_i == CMD_LOCK_BOT);
    end
  end

  assign blocked  = |(in_reg & lock_q);
  assign any_lock = |lock_q;
  assign prog_d   = (cmd_i == CMD_PROG) && !blocked;
  assign page_d   = (cmd_i == CMD_PAGE) && !blocked;
  assign chip_d   = (cmd_i == CMD_CHIP) && !any_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q       <= '0;
      prog_start_o <= 1'b0;
      chip_erase_o <= 1'b0;
      page_erase_o <= 1'b0;
      op_addr_o    <= '0;
      op_data_o    <= '0;
    end else begin
      lock_q       <= lock_q | lock_set;
      prog_start_o <= prog_d;
      chip_erase_o <= chip_d;
      page_erase_o <= page_d;
      if (prog_d || chip_d || page_d) begin
        op_addr_o <= cmd_addr_i;
        op_data_o <= cmd_data_i;
      end
    end
  end

  assign lock_top_o = lock_q[1];
  assign lock_bot_o = lock_q[0];

  // R2
  one_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, chip_erase_o, page_erase_o}));

  // R5
  top_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_top_o |=> lock_top_o);

  // R5
  bot_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_bot_o |=> lock_bot_o);

  // R10
  start_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o || page_erase_o) |->
      !(lock_top_o && (&op_addr_o[ADDR_W-1:BOOT_W])) &&
      !(lock_bot_o && (~|op_addr_o[ADDR_W-1:BOOT_W])));

  // R10
  chip_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> !lock_top_o && !lock_bot_o);

endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MAKER_ID  = 'hC5,
  parameter logic [DATA_W-1:0] DEVICE_ID = 'h1B
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              lock_top_i,
  input  logic              lock_bot_i,
  output logic [DATA_W-1:0] id_data_o
);

  localparam logic [ADDR_W-1:0] BOT_STAT_A = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] TOP_STAT_A = {{(ADDR_W-4){1'b1}}, 4'h2};

  always_comb begin
    id_data_o = '0;
    if (id_mode_i) begin
      if (rd_addr_i == BOT_STAT_A)      id_data_o = DATA_W'(lock_bot_i);
      else if (rd_addr_i == TOP_STAT_A) id_data_o = DATA_W'(lock_top_i);
      else if (rd_addr_i[7:0] == 8'h00) id_data_o = MAKER_ID;
      else if (rd_addr_i[7:0] == 8'h01) id_data_o = DEVICE_ID;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BOOT_W = 13,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h2AAA,
  parameter logic [DATA_W-1:0] MAKER_ID   = 'hC5,
  parameter logic [DATA_W-1:0] DEVICE_ID  = 'h1B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prog_start_o,
  output logic              chip_erase_o,
  output logic              page_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] id_data_o,
  output logic              lock_top_o,
  output logic              lock_bot_o
);

  cmd_e              cmd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;

  fcd_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .busy_i(busy_i),
    .cmd_o(cmd), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .id_mode_o(id_mode_o)
  );

  fcd_guard #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_W(BOOT_W)
  ) i_guard (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_i(cmd), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .prog_start_o(prog_start_o), .chip_erase_o(chip_erase_o),
    .page_erase_o(page_erase_o),
    .op_addr_o(op_addr_o), .op_data_o(op_data_o),
    .lock_top_o(lock_top_o), .lock_bot_o(lock_bot_o)
  );

  fcd_id_read #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)
  ) i_id (
    .id_mode_i(id_mode_o), .rd_addr_i(rd_addr_i),
    .lock_top_i(lock_top_o), .lock_bot_i(lock_bot_o),
    .id_data_o(id_data_o)
  );

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        prog_start_o, chip_erase_o, page_erase_o;
  logic [15:0] op_addr_o;
  logic [7:0]  op_data_o;
  logic        id_mode_o, lock_top_o, lock_bot_o;
  logic [7:0]  id_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [2:0] got_pulse;

  always #4 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_i(busy), .rd_addr_i(rd_addr),
    .prog_start_o(prog_start_o), .chip_erase_o(chip_erase_o),
    .page_erase_o(page_erase_o), .op_addr_o(op_addr_o), .op_data_o(op_data_o),
    .id_mode_o(id_mode_o), .id_data_o(id_data_o),
    .lock_top_o(lock_top_o), .lock_bot_o(lock_bot_o)
  );

  // {busy, addr, data, pulse{page,chip,prog}, id_mode}
  localparam int NV = 38;
  localparam logic [28:0] VEC [0:NV-1] = '{
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R2 program
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'hA0,3'b000,1'b0},
    {1'b0,16'h1234,8'h5A,3'b001,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R3 chip erase
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'h80,3'b000,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'h10,3'b010,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R4 page erase
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'h80,3'b000,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h7ABC,8'h50,3'b100,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R6 id entry
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'h90,3'b000,1'b1},
    {1'b0,16'h5555,8'hAA,3'b000,1'b1},  // R8 wrong address aborts, clears id
    {1'b0,16'h2AAB,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R9 busy write ignored
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'hA0,3'b000,1'b0},
    {1'b1,16'h0000,8'hFF,3'b000,1'b0},
    {1'b0,16'h4321,8'hC3,3'b001,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R8 wrong data aborts
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'hA1,3'b000,1'b0},
    {1'b0,16'h1111,8'h22,3'b000,1'b0},
    {1'b0,16'h5555,8'hAA,3'b000,1'b0},  // R8 abort mid erase prefix
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'h80,3'b000,1'b0},
    {1'b0,16'h5555,8'hAB,3'b000,1'b0},
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0},
    {1'b0,16'h5555,8'h10,3'b000,1'b0},
    {1'b1,16'h5555,8'hAA,3'b000,1'b0},  // R9 busy key write does not start
    {1'b0,16'h2AAA,8'h55,3'b000,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    got_pulse = {page_erase_o, chip_erase_o, prog_start_o};
    wr_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA, 1'b0);
    wr(16'h2AAA, 8'h55, 1'b0);
  endtask

  task automatic six(input logic [15:0] a, input logic [7:0] d);
    unlock();
    wr(16'h5555, 8'h80, 1'b0);
    unlock();
    wr(a, d, 1'b0);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    unlock();
    wr(16'h5555, 8'hA0, 1'b0);
    wr(a, d, 1'b0);
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pulses", {29'd0, page_erase_o, chip_erase_o, prog_start_o}, 0);
    chk("R1 id_mode", id_mode_o, 0);
    chk("R1 locks", {lock_top_o, lock_bot_o}, 0);
    chk("R1 id_data", id_data_o, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][27:12], VEC[i][11:4], VEC[i][28]);
      chk($sformatf("R2/R3/R4/R8/R9 vec%0d pulse", i), got_pulse, VEC[i][3:1]);
      chk($sformatf("R6/R8 vec%0d id_mode", i), id_mode_o, VEC[i][0]);
      if (VEC[i][3:1] != 3'b000) begin
        chk($sformatf("R2/R4 vec%0d op_addr", i), op_addr_o, VEC[i][27:12]);
        chk($sformatf("R2 vec%0d op_data", i), op_data_o, VEC[i][11:4]);
      end
    end

    // R7 identification reads, R6 single-write exit
    unlock(); wr(16'h5555, 8'h90, 1'b0);
    chk("R6 id entry", id_mode_o, 1);
    rd(16'h0000); chk("R7 maker", id_data_o, 8'hC5);
    rd(16'h0001); chk("R7 device", id_data_o, 8'h1B);
    rd(16'h3400); chk("R7 maker low byte", id_data_o, 8'hC5);
    rd(16'h0002); chk("R7 bottom status", id_data_o, 8'h00);
    rd(16'h0005); chk("R7 other", id_data_o, 8'h00);
    wr(16'h1234, 8'hF0, 1'b0);
    chk("R6 single exit", id_mode_o, 0);
    rd(16'h0000); chk("R7 outside id", id_data_o, 8'h00);

    // R6 three-write exit
    unlock(); wr(16'h5555, 8'h90, 1'b0);
    unlock(); wr(16'h5555, 8'hF0, 1'b0);
    chk("R6 three-write exit", id_mode_o, 0);

    // R5 bad lock address
    six(16'h5555, 8'h70); wr(16'hFFFE, 8'h00, 1'b0);
    chk("R5 bad lock addr", {lock_top_o, lock_bot_o}, 0);

    // R5 lock top
    six(16'h5555, 8'h70); wr(16'hFFFF, 8'h3C, 1'b0);
    chk("R5 top set", {lock_top_o, lock_bot_o}, 2'b10);
    unlock(); wr(16'h5555, 8'h90, 1'b0);
    rd(16'hFFF2); chk("R7 top status", id_data_o, 8'h01);
    rd(16'h0002); chk("R7 bottom status clear", id_data_o, 8'h00);
    wr(16'h0000, 8'hF0, 1'b0);

    // R10 suppression with top locked
    prog(16'hE000, 8'h11); chk("R10 prog top locked", got_pulse, 3'b000);
    prog(16'h2000, 8'h22); chk("R10 prog unlocked", got_pulse, 3'b001);
    six(16'hF123, 8'h50);  chk("R10 page top locked", got_pulse, 3'b000);
    six(16'hD000, 8'h50);  chk("R10 page unlocked", got_pulse, 3'b100);
    chk("R4 page addr", op_addr_o, 16'hD000);
    six(16'h5555, 8'h10);  chk("R10 chip locked", got_pulse, 3'b000);

    // R5 lock bottom, R10 suppression
    six(16'h5555, 8'h70); wr(16'h0000, 8'h00, 1'b0);
    chk("R5 both set", {lock_top_o, lock_bot_o}, 2'b11);
    prog(16'h1FFF, 8'h33); chk("R10 prog bottom locked", got_pulse, 3'b000);
    six(16'h1000, 8'h50);  chk("R10 page bottom locked", got_pulse, 3'b000);
    prog(16'h2000, 8'h44); chk("R10 prog middle", got_pulse, 3'b001);
    wr(16'h0000, 8'h00, 1'b0);
    chk("R5 locks sticky", {lock_top_o, lock_bot_o}, 2'b11);

    // R1 reset clears locks
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 locks after reset", {lock_top_o, lock_bot_o}, 0);
    chk("R1 id after reset", id_mode_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule